// File: doc/BRIEF.md
# Response Framer for a Block-Transfer Host Mailbox

This block sits between the management controller and the output side of a byte-wide host mailbox. The controller hands over each response as a stream of bytes: network function, command, completion code, then any data. An identifier comes with the stream. The block compares that identifier with the one it expects next. A matching response is turned into the frame the host reads, one byte per strobe, from the output buffer. A response with any other identifier is drained and thrown away.

A built frame starts with its own length byte. The sequence number saved from the request is inserted as the third byte. A response too long for the buffer is replaced by a fixed five-byte error frame. When a frame is loaded, the block clears the controller busy flag and raises the attention flag towards the host. It also sets the interrupt pending flag when the interrupt is enabled.

Top module: `bt_rsp_framer`

## Requirements
- R1: After reset the expected identifier is 0, busy, attention and interrupt pending are low, the output length is 0, and `rdData` reads 8'hFF.
- R2: A response is accepted only when `rspId`, sampled with its first byte, equals `expId`. The acceptance completes on the clock edge that takes the last byte, and on that edge `expId` increments by 1, wrapping modulo 256.
- R3: A response whose identifier does not match changes nothing: identifier, flags, output length, read position and buffer contents all keep their values.
- R4: An accepted response of N bytes with N <= DEPTH-2 yields N+2 output bytes in this order: N+1, the network function (stream byte 0), `savedSeq`, then stream bytes 1 to N-1.
- R5: An accepted response with N > DEPTH-2 yields exactly 5 bytes in this order: 4, network function, `savedSeq`, command (stream byte 1), 8'hCA. With N = DEPTH-2 the normal frame of R4 is produced, giving `outLen` = DEPTH.
- R6: On the edge that loads a frame, `bmcBusy` goes low and `b2hAtn` goes high.
- R7: On loading a frame, `irqPend` is set only if `irqEn` is high. While `irqEn` is low it is not set. `irqAck` clears it.
- R8: Each `rdEn` strobe while bytes remain moves to the next byte. After the last byte is read, `outLen` returns to 0. While the buffer is empty, `rdData` reads 8'hFF.
- R9: Loading a new frame resets the read position to 0, even if the previous frame was only partly read.
- R10: `reqStart` sets `bmcBusy`; `atnClr` clears `b2hAtn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | Response byte valid |
| rspLast | input | 1 | Marks the last byte of a response |
| rspData | input | 8 | Response byte |
| rspId | input | 8 | Response identifier, sampled with the first byte |
| savedSeq | input | 8 | Sequence number saved from the request |
| reqStart | input | 1 | Host handed over a request; sets busy |
| atnClr | input | 1 | Host clears attention |
| irqEn | input | 1 | Interrupt enable level |
| irqAck | input | 1 | Host clears pending interrupt |
| rdEn | input | 1 | Host read strobe; advances the read position |
| rdData | output | 8 | Byte at the current read position, or 8'hFF when empty |
| outLen | output | $clog2(DEPTH+1) | Bytes in the loaded frame (0 = empty) |
| expId | output | 8 | Identifier expected for the next response |
| bmcBusy | output | 1 | Controller busy flag |
| b2hAtn | output | 1 | Attention flag towards the host |
| irqPend | output | 1 | Interrupt pending |

## Verification
The assertions assume that `reqStart` never arrives on the edge that loads a frame. They also assume that `irqAck` is pulsed only while no frame is being loaded, so that each flag has one source in any given cycle. The bench respects this by driving host strobes only between responses. It also finishes or abandons each host read before the next response starts. A response therefore never overwrites the buffer while that buffer is being read.

// File: rtl/btfr_pkg.sv
package btfr_pkg;
  typedef struct packed {
    logic capture;  // store the current stream byte
    logic first;    // current byte is the first of an accepted response
    logic commit;   // current byte is the last of an accepted response
  } btfr_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAKE = 2'd1,
    ST_DROP = 2'd2
  } btfr_state_t;

  localparam logic [7:0] ERR_TOO_LONG_CC = 8'hCA;
  localparam logic [7:0] ERR_FRAME_LEN   = 8'd4;
  localparam logic [7:0] EMPTY_READ      = 8'hFF;
endpackage

// File: rtl/btfr_control.sv
module btfr_control
  import btfr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rspValid,
  input  logic         rspLast,
  input  logic [7:0]   rspId,
  input  logic         reqStart,
  input  logic         atnClr,
  input  logic         irqEn,
  input  logic         irqAck,
  output btfr_strobe_t strobe,
  output logic [7:0]   expId,
  output logic         bmcBusy,
  output logic         b2hAtn,
  output logic         irqPend
);
  btfr_state_t state, stateNext;
  logic idMatch;

  assign idMatch = (rspId == expId);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (rspValid) begin
      unique case (state)
        ST_IDLE: begin
          if (idMatch) begin
            strobe.capture = 1'b1;
            strobe.first   = 1'b1;
            strobe.commit  = rspLast;
            stateNext      = rspLast ? ST_IDLE : ST_TAKE;
          end else begin
            stateNext = rspLast ? ST_IDLE : ST_DROP;
          end
        end
        ST_TAKE: begin
          strobe.capture = 1'b1;
          strobe.commit  = rspLast;
          if (rspLast) stateNext = ST_IDLE;
        end
        ST_DROP: begin
          if (rspLast) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      expId   <= 8'd0;
      bmcBusy <= 1'b0;
      b2hAtn  <= 1'b0;
      irqPend <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.commit) begin
        expId   <= expId + 8'd1;
        bmcBusy <= 1'b0;
        b2hAtn  <= 1'b1;
      end else begin
        if (reqStart) bmcBusy <= 1'b1;
        if (atnClr)   b2hAtn  <= 1'b0;
      end
      irqPend <= (irqPend & ~irqAck) | (strobe.commit & irqEn);
    end
  end
endmodule

// File: rtl/btfr_datapath.sv
module btfr_datapath
  import btfr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int OUT_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(DEPTH + 2) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  btfr_strobe_t     strobe,
  input  logic [7:0]       rspData,
  input  logic [7:0]       savedSeq,
  input  logic             rdEn,
  output logic [7:0]       rdData,
  output logic [OUT_W-1:0] outLen
);
  localparam int SAT = DEPTH + 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH - 2);

  logic [7:0]       frameBuf [DEPTH];
  logic [CNT_W-1:0] cnt;        // bytes already taken from this response
  logic [CNT_W-1:0] curIdx;     // count including the current byte minus one
  logic [CNT_W-1:0] curLen;     // response length if this byte is last
  logic [CNT_W-1:0] wrIdx;
  logic             overlong;
  logic [OUT_W-1:0] rdPos;
  logic             haveData;

  assign curIdx   = strobe.first ? '0 : cnt;
  assign curLen   = curIdx + CNT_W'(1);
  assign wrIdx    = (curIdx == '0) ? CNT_W'(1) : curIdx + CNT_W'(2);
  assign overlong = curLen > LIMIT;
  assign haveData = rdPos < outLen;
  assign rdData   = haveData ? frameBuf[rdPos] : EMPTY_READ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.capture) begin
      cnt <= (curLen >= CNT_W'(SAT)) ? CNT_W'(SAT) : curLen;
    end
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          frameBuf[e] <= 8'd0;
        end else if (strobe.commit && e == 0) begin
          frameBuf[e] <= overlong ? ERR_FRAME_LEN : 8'(curLen + CNT_W'(1));
        end else if (strobe.commit && e == 2) begin
          frameBuf[e] <= savedSeq;
        end else if (strobe.commit && overlong && e == 4) begin
          frameBuf[e] <= ERR_TOO_LONG_CC;
        end else if (strobe.capture && wrIdx == CNT_W'(e)) begin
          frameBuf[e] <= rspData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLen <= '0;
      rdPos  <= '0;
    end else if (strobe.commit) begin
      outLen <= overlong ? OUT_W'(5) : OUT_W'(curLen + CNT_W'(2));
      rdPos  <= '0;
    end else if (rdEn && haveData) begin
      if (rdPos + OUT_W'(1) == outLen) begin
        rdPos  <= '0;
        outLen <= '0;
      end else begin
        rdPos <= rdPos + OUT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bt_rsp_framer.sv
module bt_rsp_framer
  import btfr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int OUT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rspValid,
  input  logic             rspLast,
  input  logic [7:0]       rspData,
  input  logic [7:0]       rspId,
  input  logic [7:0]       savedSeq,
  input  logic             reqStart,
  input  logic             atnClr,
  input  logic             irqEn,
  input  logic             irqAck,
  input  logic             rdEn,
  output logic [7:0]       rdData,
  output logic [OUT_W-1:0] outLen,
  output logic [7:0]       expId,
  output logic             bmcBusy,
  output logic             b2hAtn,
  output logic             irqPend
);
  btfr_strobe_t strobe;

  btfr_control ctrl_i (
    .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspLast(rspLast),
    .rspId(rspId), .reqStart(reqStart), .atnClr(atnClr), .irqEn(irqEn),
    .irqAck(irqAck), .strobe(strobe), .expId(expId), .bmcBusy(bmcBusy),
    .b2hAtn(b2hAtn), .irqPend(irqPend)
  );

  btfr_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rspData(rspData),
    .savedSeq(savedSeq), .rdEn(rdEn), .rdData(rdData), .outLen(outLen)
  );
endmodule

// File: rtl/btfr_checker.sv
module btfr_checker #(
  parameter int DEPTH = 16,
  localparam int OUT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqStart,
  input logic             atnClr,
  input logic             irqEn,
  input logic             irqAck,
  input logic [OUT_W-1:0] outLen,
  input logic [7:0]       expId,
  input logic             bmcBusy,
  input logic             b2hAtn,
  input logic             irqPend
);
  // R2: the identifier only ever steps by one
  assert_id_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(expId) |-> expId == 8'($past(expId) + 8'd1));

  // R6: a loaded frame leaves busy low and attention high
  assert_handshake_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(expId) |-> (!bmcBusy && b2hAtn));

  // R7: pending only rises while the enable was on
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> $past(irqEn));

  // R7: acknowledge with enable off always clears
  assert_irq_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqEn) |=> !irqPend);

  // R8: the frame never claims more bytes than the buffer holds
  assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    outLen <= OUT_W'(DEPTH));

  // R10: host request start raises busy
  assert_busy_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqStart |=> (bmcBusy || !$stable(expId)));

  // R10: attention clear drops attention unless a frame loads
  assert_atn_clr_R10: assert property (@(posedge clk) disable iff (!rstN)
    atnClr |=> (!b2hAtn || !$stable(expId)));
endmodule

bind bt_rsp_framer btfr_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .reqStart(reqStart), .atnClr(atnClr),
  .irqEn(irqEn), .irqAck(irqAck), .outLen(outLen), .expId(expId),
  .bmcBusy(bmcBusy), .b2hAtn(b2hAtn), .irqPend(irqPend)
);

// File: tb/bt_rsp_framer_tb_top.sv
module bt_rsp_framer_tb_top;
  localparam int DEPTH = 16;
  localparam int OUT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rspValid = 1'b0, rspLast = 1'b0;
  logic [7:0] rspData = 8'd0, rspId = 8'd0, savedSeq = 8'd0;
  logic reqStart = 1'b0, atnClr = 1'b0, irqEn = 1'b0, irqAck = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData;
  logic [OUT_W-1:0] outLen;
  logic [7:0] expId;
  logic bmcBusy, b2hAtn, irqPend;

  int errors = 0;
  int checks = 0;
  logic [7:0] pay[$];
  logic [7:0] expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  bt_rsp_framer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspLast(rspLast),
    .rspData(rspData), .rspId(rspId), .savedSeq(savedSeq),
    .reqStart(reqStart), .atnClr(atnClr), .irqEn(irqEn), .irqAck(irqAck),
    .rdEn(rdEn), .rdData(rdData), .outLen(outLen), .expId(expId),
    .bmcBusy(bmcBusy), .b2hAtn(b2hAtn), .irqPend(irqPend)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: stream pay[] with identifier id; push expected frame when accepted.
  task automatic sendRsp(input logic [7:0] id, input logic [7:0] seq, input bit accept);
    int n = pay.size();
    if (accept) begin
      expQ.delete();
      if (n > DEPTH - 2) begin
        expQ.push_back(8'd4); expQ.push_back(pay[0]); expQ.push_back(seq);
        expQ.push_back(pay[1]); expQ.push_back(8'hCA);
      end else begin
        expQ.push_back(8'(n + 1)); expQ.push_back(pay[0]); expQ.push_back(seq);
        for (int i = 1; i < n; i++) expQ.push_back(pay[i]);
      end
    end
    savedSeq = seq;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rspValid = 1'b1; rspData = pay[i]; rspId = id; rspLast = (i == n - 1);
    end
    @(negedge clk);
    rspValid = 1'b0; rspLast = 1'b0;
    #1;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    #1;
  endtask

  // Monitor: read nBytes and compare against the expected queue.
  task automatic readBytes(input int nBytes, input string req);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk); #1;
      if (expQ.size() == 0) chk({req, " queue"}, 1, 0);
      else chk(req, rdData, expQ.pop_front());
      rdEn = 1'b1;
      @(negedge clk); rdEn = 1'b0;
    end
    #1;
  endtask

  task automatic mkPay(input int n, input logic [7:0] base);
    pay.delete();
    for (int i = 0; i < n; i++) pay.push_back(8'(base + 8'(i * 3)));
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 expId", expId, 0); chk("R1 busy", bmcBusy, 0);
    chk("R1 atn", b2hAtn, 0); chk("R1 irq", irqPend, 0);
    chk("R1 outLen", outLen, 0); chk("R1 rdData", rdData, 8'hFF);

    // R10 request start
    pulse(reqStart);
    chk("R10 busy set", bmcBusy, 1);

    // R2 R4 R6 R7 normal frame with irq enabled
    irqEn = 1'b1;
    pay = '{8'h1C, 8'h01, 8'h00, 8'hAA, 8'hBB};
    sendRsp(8'd0, 8'h33, 1'b1);
    chk("R2 expId inc", expId, 1);
    chk("R4 outLen", outLen, 7);
    chk("R6 busy clr", bmcBusy, 0); chk("R6 atn set", b2hAtn, 1);
    chk("R7 irq set", irqPend, 1);
    // R3 mismatch while frame loaded
    pulse(reqStart);
    mkPay(6, 8'h50);
    sendRsp(8'd9, 8'h77, 1'b0);
    chk("R3 expId", expId, 1); chk("R3 outLen", outLen, 7);
    chk("R3 busy", bmcBusy, 1); chk("R3 irq", irqPend, 1);
    readBytes(7, "R4 R3 byte");
    chk("R8 outLen empty", outLen, 0); chk("R8 empty read", rdData, 8'hFF);

    // R10 attention clear, R7 ack
    pulse(atnClr);
    chk("R10 atn clr", b2hAtn, 0);
    irqEn = 1'b0;
    pulse(irqAck);
    chk("R7 ack", irqPend, 0);

    // R7 no irq when disabled; R5 overlong
    mkPay(DEPTH - 1, 8'h20);
    sendRsp(8'd1, 8'h44, 1'b1);
    chk("R7 irq gated", irqPend, 0);
    chk("R5 outLen", outLen, 5); chk("R2 expId", expId, 2);
    readBytes(5, "R5 byte");
    chk("R8 done", outLen, 0);

    // R5 boundary: length DEPTH-2 gives full buffer
    mkPay(DEPTH - 2, 8'h61);
    sendRsp(8'd2, 8'h05, 1'b1);
    chk("R5 boundary outLen", outLen, DEPTH);
    readBytes(DEPTH, "R5 boundary byte");
    chk("R8 after full", rdData, 8'hFF);

    // R4 single-byte response
    pay = '{8'h2D};
    sendRsp(8'd3, 8'h9E, 1'b1);
    chk("R4 one-byte outLen", outLen, 3);
    readBytes(3, "R4 one-byte byte");

    // R9 partial read then new frame restarts at 0
    mkPay(4, 8'h90);
    sendRsp(8'd4, 8'h11, 1'b1);
    readBytes(2, "R9 partial");
    mkPay(3, 8'hC0);
    sendRsp(8'd5, 8'h22, 1'b1);
    chk("R9 outLen", outLen, 5);
    readBytes(5, "R9 restart byte");

    // R2 wrap of the identifier
    for (int k = 6; k < 256; k++) begin
      pay = '{8'h04, 8'h01};
      sendRsp(8'(k), 8'h00, 1'b1);
    end
    chk("R2 before wrap", expId, 0);
    pay = '{8'h18, 8'h02, 8'h00};
    sendRsp(8'd0, 8'h3C, 1'b1);
    chk("R2 wrap accept", expId, 1);
    readBytes(5, "R2 wrap byte");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule